// File: doc/BRIEF.md
# Cache-Block Zero Write Engine

This engine clears one cache block of memory on command. A single-cycle start request carries an arbitrary byte address. The engine rounds that address down to the start of its block, whose size in bytes is a power-of-two parameter (64 by default). It then asks an external checker whether a store to the whole block is allowed. If the answer is yes, it writes zeros over the full block through a word-wide write port, one word per accepted beat, at rising addresses. If the answer is no, it ends with a fault and touches no memory.

Completion is reported by a one-cycle `done` pulse, and a refusal by a one-cycle `fault` pulse. After either pulse the engine is idle again. The caller is responsible for every configuration-level enable check. A start request is issued only once those checks have passed. Start requests that arrive while the engine is busy are dropped. The permission checker and the memory sit outside the block.

Top module: `cbz_zero_engine`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `busy`, `perm_req`, `wr_valid`, `done` and `fault` are all low.
- R2: The block base equals `req_addr` with its low log2(BLK_BYTES) bits forced to zero. `perm_addr` shows this base for as long as `perm_req` is high.
- R3: No write is presented while the permission check is pending. `perm_req` stays high, with a stable `perm_addr`, until `perm_ack` is seen.
- R4: A check answered with `perm_ok` low produces `fault` high in the next cycle. No write beat is issued for that operation.
- R5: A granted check produces exactly BLK_BYTES/(DATA_W/8) write beats. Beat i uses address base + i*(DATA_W/8), and every beat carries all-zero `wr_data`.
- R6: A presented beat keeps `wr_valid` high and `wr_addr` unchanged until `wr_ready` is high.
- R7: `done` rises in the cycle after the last beat is accepted. In the following cycle the engine is idle (`busy` low).
- R8: A `req_valid` seen while `busy` is high is ignored. It changes neither the base under check nor the base being written.
- R9: `done` and `fault` are never high together. Each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start pulse, accepted only while idle |
| req_addr | input | ADDR_W | Byte address anywhere inside the target block |
| busy | output | 1 | High from the cycle after a start until the engine returns to idle |
| perm_req | output | 1 | Store-permission query for the aligned block |
| perm_addr | output | ADDR_W | Aligned block base under query |
| perm_ack | input | 1 | Permission answer valid |
| perm_ok | input | 1 | Permission granted (sampled with `perm_ack`) |
| wr_valid | output | 1 | Write beat presented |
| wr_addr | output | ADDR_W | Byte address of the current beat |
| wr_data | output | DATA_W | Beat data, always zero |
| wr_ready | input | 1 | Memory accepts the presented beat |
| done | output | 1 | One-cycle pulse: block cleared |
| fault | output | 1 | One-cycle pulse: permission refused |

## Verification
The bench builds the engine with a 16-bit address, a 32-byte block and a 64-bit word. This gives four beats per block, so the beat counter wraps within a few cycles. Every one of the 32 byte offsets inside a block is swept, at a low base, a mid base and the block at the very top of the address space. This covers alignment of each offset and address arithmetic up to the final word of memory. The sweep alternates grant and refusal and varies the `wr_ready` back-pressure from zero to two stall cycles. Spurious start requests are driven throughout every operation.

// File: rtl/cbz_pkg.sv
package cbz_pkg;
   typedef enum logic [1:0] {
      CBZ_IDLE  = 2'd0,
      CBZ_CHECK = 2'd1,
      CBZ_WRITE = 2'd2,
      CBZ_DONE  = 2'd3
   } cbz_state_e;
endpackage

// File: rtl/cbz_align.sv
module cbz_align #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 6
) (
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] base_out
);
   generate
      if (OFF_W == 0) begin : g_pass
         assign base_out = addr_in;
      end else begin : g_mask
         assign base_out = {addr_in[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/cbz_beat_gen.sv
module cbz_beat_gen #(
   parameter int ADDR_W     = 32,
   parameter int BEATS      = 8,
   parameter int BEAT_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] beat_addr,
   output logic              last
);
   localparam int BEAT_SH = $clog2(BEAT_BYTES);

   generate
      if (BEATS == 1) begin : g_single
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, clear, advance};
         assign beat_addr = base;
         assign last      = 1'b1;
      end else begin : g_multi
         localparam int CNT_W = $clog2(BEATS);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               cnt_q <= '0;
            end else if (advance) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign last      = (cnt_q == CNT_W'(BEATS - 1));
         assign beat_addr = base + (ADDR_W'(cnt_q) << BEAT_SH);
      end
   endgenerate
endmodule

// File: rtl/cbz_ctrl.sv
module cbz_ctrl
   import cbz_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       perm_ack,
   input  logic       perm_ok,
   input  logic       wr_ready,
   input  logic       last_beat,
   output logic       take,
   output logic       beat_clear,
   output logic       beat_adv,
   output logic       perm_req,
   output logic       wr_valid,
   output logic       busy,
   output logic       done,
   output logic       fault
);
   cbz_state_e state_q, state_d;
   logic       denied_q, denied_d;

   always_comb begin
      state_d  = state_q;
      denied_d = denied_q;
      unique case (state_q)
         CBZ_IDLE: begin
            if (req_valid) begin
               state_d  = CBZ_CHECK;
               denied_d = 1'b0;
            end
         end
         CBZ_CHECK: begin
            if (perm_ack) begin
               state_d  = perm_ok ? CBZ_WRITE : CBZ_DONE;
               denied_d = !perm_ok;
            end
         end
         CBZ_WRITE: begin
            if (wr_ready && last_beat) state_d = CBZ_DONE;
         end
         CBZ_DONE: state_d = CBZ_IDLE;
         default:  state_d = CBZ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= CBZ_IDLE;
         denied_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         denied_q <= denied_d;
      end
   end

   assign take       = (state_q == CBZ_IDLE) && req_valid;
   assign beat_clear = (state_q == CBZ_CHECK);
   assign beat_adv   = (state_q == CBZ_WRITE) && wr_ready;
   assign perm_req   = (state_q == CBZ_CHECK);
   assign wr_valid   = (state_q == CBZ_WRITE);
   assign busy       = (state_q != CBZ_IDLE);
   assign done       = (state_q == CBZ_DONE) && !denied_q;
   assign fault      = (state_q == CBZ_DONE) && denied_q;
endmodule

// File: rtl/cbz_zero_engine.sv
module cbz_zero_engine #(
   parameter int ADDR_W    = 32,
   parameter int BLK_BYTES = 64,
   parameter int DATA_W    = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              busy,
   output logic              perm_req,
   output logic [ADDR_W-1:0] perm_addr,
   input  logic              perm_ack,
   input  logic              perm_ok,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ready,
   output logic              done,
   output logic              fault
);
   localparam int BEAT_BYTES = DATA_W / 8;
   localparam int BEATS      = BLK_BYTES / BEAT_BYTES;
   localparam int OFF_W      = $clog2(BLK_BYTES);

   generate
      if (BLK_BYTES < 1 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
         $error("cbz_zero_engine: BLK_BYTES must be a power of two");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0 || (BEAT_BYTES & (BEAT_BYTES - 1)) != 0) begin : g_bad_dw
         $error("cbz_zero_engine: DATA_W must be 8 times a power of two");
      end
      if (BLK_BYTES < BEAT_BYTES) begin : g_bad_ratio
         $error("cbz_zero_engine: block must hold at least one word");
      end
      if (OFF_W >= ADDR_W) begin : g_bad_aw
         $error("cbz_zero_engine: ADDR_W too small for the block size");
      end
   endgenerate

   logic              take, beat_clear, beat_adv, last_beat;
   logic [ADDR_W-1:0] aligned, base_q;

   cbz_align #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_align (
      .addr_in  (req_addr),
      .base_out (aligned)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (take) begin
         base_q <= aligned;
      end
   end

   cbz_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .perm_ack   (perm_ack),
      .perm_ok    (perm_ok),
      .wr_ready   (wr_ready),
      .last_beat  (last_beat),
      .take       (take),
      .beat_clear (beat_clear),
      .beat_adv   (beat_adv),
      .perm_req   (perm_req),
      .wr_valid   (wr_valid),
      .busy       (busy),
      .done       (done),
      .fault      (fault)
   );

   cbz_beat_gen #(.ADDR_W(ADDR_W), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES)) u_beats (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (beat_clear),
      .advance   (beat_adv),
      .base      (base_q),
      .beat_addr (wr_addr),
      .last      (last_beat)
   );

   assign perm_addr = base_q;
   assign wr_data   = '0;
endmodule

// File: rtl/cbz_zero_engine_chk.sv
module cbz_zero_engine_chk #(
   parameter int ADDR_W    = 32,
   parameter int BLK_BYTES = 64,
   parameter int DATA_W    = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              perm_req,
   input logic [ADDR_W-1:0] perm_addr,
   input logic              perm_ack,
   input logic              perm_ok,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_ready,
   input logic              done,
   input logic              fault
);
   localparam int OFF_W = $clog2(BLK_BYTES);
   localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);
   localparam logic [ADDR_W-1:0] BEAT_MASK = ADDR_W'(DATA_W / 8 - 1);

   p_perm_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      perm_req |-> ((perm_addr & OFF_MASK) == '0));

   p_no_write_in_check_r3: assert property (@(posedge clk) disable iff (!rst_n)
      perm_req |-> !wr_valid);

   p_perm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (perm_req && !perm_ack) |=> (perm_req && $stable(perm_addr)));

   p_deny_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (perm_req && perm_ack && !perm_ok) |=> (fault && !wr_valid));

   p_zero_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_data == '0 && (wr_addr & BEAT_MASK) == '0));

   p_grant_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (perm_req && perm_ack && perm_ok) |=> wr_valid);

   p_beat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

   p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fault) |=> !busy);

   p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fault) |=> !(done || fault));

   logic unused_ok;
   assign unused_ok = &{1'b0, OFF_W[0]};
endmodule

bind cbz_zero_engine cbz_zero_engine_chk #(
   .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .perm_req(perm_req),
   .perm_addr(perm_addr), .perm_ack(perm_ack), .perm_ok(perm_ok),
   .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
   .wr_ready(wr_ready), .done(done), .fault(fault)
);

// File: tb/cbz_zero_engine_tb.sv
module cbz_zero_engine_tb;
   localparam int AW    = 16;
   localparam int BLK   = 32;
   localparam int DW    = 64;
   localparam int BB    = DW / 8;
   localparam int NBEAT = BLK / BB;
   localparam int LIMIT = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          perm_ack = 1'b0, perm_ok = 1'b0, wr_ready = 1'b0;
   logic          busy, perm_req, wr_valid, done, fault;
   logic [AW-1:0] perm_addr, wr_addr;
   logic [DW-1:0] wr_data;

   int tests = 0;
   int fails = 0;
   int wcount = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   cbz_zero_engine #(.ADDR_W(AW), .BLK_BYTES(BLK), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .busy(busy), .perm_req(perm_req), .perm_addr(perm_addr),
      .perm_ack(perm_ack), .perm_ok(perm_ok), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .done(done), .fault(fault)
   );

   always @(posedge clk) begin
      if (rst_n && wr_valid && wr_ready) wcount <= wcount + 1;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic check_quiet(input string tag);
      chk(!busy && !perm_req && !wr_valid && !done && !fault, tag,
          {busy, perm_req, wr_valid, done, fault}, 0);
   endtask

   task automatic do_op(input logic [AW-1:0] a, input bit allow, input int gap);
      logic [AW-1:0] base;
      int            w0;
      base = a & ~AW'(BLK - 1);
      w0   = wcount;
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      // now checking; keep a spurious request on the port (R8)
      req_addr = ~a;
      chk(perm_req && busy && !wr_valid, "R3 check phase", {perm_req, busy, wr_valid}, 3'b110);
      chk(perm_addr == base, "R2 aligned base", perm_addr, base);
      for (int h = 0; h < 2; h++) begin
         @(negedge clk);
         chk(perm_req && !wr_valid, "R3 pending check holds", {perm_req, wr_valid}, 2'b10);
         chk(perm_addr == base, "R8 base kept while busy", perm_addr, base);
      end
      perm_ack = 1'b1;
      perm_ok  = allow;
      @(negedge clk);
      perm_ack = 1'b0;
      perm_ok  = 1'b0;
      if (!allow) begin
         chk(fault && !done && !wr_valid, "R4 fault pulse", {fault, done, wr_valid}, 3'b100);
         req_valid = 1'b0;
         @(negedge clk);
         chk(!fault && !busy, "R9 fault single cycle", {fault, busy}, 0);
         chk(wcount == w0, "R4 no writes on deny", wcount - w0, 0);
      end else begin
         for (int i = 0; i < NBEAT; i++) begin
            for (int g = 0; g < gap; g++) begin
               chk(wr_valid && wr_addr == base + AW'(i * BB), "R6 beat held", wr_addr, base + AW'(i * BB));
               @(negedge clk);
            end
            chk(wr_valid, "R5 beat valid", wr_valid, 1);
            chk(wr_addr == base + AW'(i * BB), "R5 beat address", wr_addr, base + AW'(i * BB));
            chk(wr_data == '0, "R5 zero data", wr_data, 0);
            wr_ready = 1'b1;
            @(negedge clk);
            wr_ready = 1'b0;
         end
         chk(done && !fault && !wr_valid, "R7 done pulse", {done, fault, wr_valid}, 3'b100);
         req_valid = 1'b0;
         @(negedge clk);
         chk(!done && !busy, "R9 done single cycle / R7 idle", {done, busy}, 0);
         chk(wcount - w0 == NBEAT, "R5 beat count", wcount - w0, NBEAT);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles >= LIMIT) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_quiet("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_quiet("R1 after reset");
      for (int off = 0; off < BLK; off++) begin
         do_op(AW'(16'h1240 + off), (off % 2) == 0, off % 3);
         do_op(AW'(16'h0000 + off), (off % 4) != 1, (off + 1) % 3);
         do_op(AW'(16'hFFE0 + off), (off % 3) != 0, (off + 2) % 3);
      end
      @(negedge clk);
      check_quiet("R8 idle after sweep");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule